// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Result Pair

This unit performs signed and unsigned multiplication and division of two WIDTH-bit operands in the background, one bit per clock cycle, and keeps the outcome in a pair of dedicated result registers, called upper and lower here. Because an operation takes many cycles, it names no destination in the general register file. Software later copies a result out with a read command or loads either register directly with a write command.

A single command port accepts one command per cycle. While an operation runs, `busy` stays high. A read issued during that time is not lost. It is remembered and answered in the cycle the result lands. New arithmetic or write commands arriving while busy are dropped. Division by zero raises nothing. It finishes in the normal time and leaves a repeatable, but unspecified, pair of values.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset `busy` and `rd_valid` are low and both result registers read back as zero.
- R2: Opcode 0 multiplies signed and opcode 1 multiplies unsigned. The 2*WIDTH-bit product is split with its high half in upper and its low half in lower. No overflow is signalled.
- R3: Opcode 2 divides signed and opcode 3 divides unsigned, with `opnd_a` as the dividend and `opnd_b` as the divisor. Lower receives the quotient and upper the remainder. A signed quotient truncates toward zero, and a signed remainder carries the sign of the dividend.
- R4: An arithmetic command accepted while idle raises `busy` in the following cycle. `busy` then stays high for exactly WIDTH+1 cycles: one setup cycle and WIDTH iteration cycles.
- R5: A read accepted while idle (opcode 4 for upper, opcode 5 for lower) drives `rd_valid` high for one cycle in the next cycle, with `rd_data` holding the selected register.
- R6: A read issued while `busy` is high, including in its last busy cycle, yields no `rd_valid` while busy. It is answered with the freshly computed value in the first cycle `busy` is low.
- R7: Arithmetic and write commands issued while `busy` is high are ignored. The running operation neither restarts nor lengthens, and neither result register changes before it completes.
- R8: A write accepted while idle loads `opnd_a` into upper (opcode 6) or lower (opcode 7), visible to the next read.
- R9: A divide by a zero divisor completes in the same WIDTH+1 busy cycles, raises nothing, and gives the same register values each time it is repeated with the same dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command opcode, encoding given in R2, R3, R5 and R8 |
| opnd_a | input | WIDTH | Multiplicand, dividend, or write data |
| opnd_b | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | An arithmetic operation is in progress |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` carries a read result |
| rd_data | output | WIDTH | Value returned by the latest read |

## Verification
The collision that matters is a read meeting the completion of an operation. A read can arrive while the iteration runs, or in the very last busy cycle, which is the same edge at which the result registers are written. The bench provokes both cases: a read one cycle after a start, and a read presented in the final busy cycle. Each is judged by requiring no strobe while busy, a strobe exactly when `busy` falls, and data equal to the new product rather than the stale register. A second overlap, commands arriving during a run, is judged by checking the busy span and the unchanged result of the original operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic [2:0] {
      OP_MUL_S = 3'd0,
      OP_MUL_U = 3'd1,
      OP_DIV_S = 3'd2,
      OP_DIV_U = 3'd3,
      OP_RD_UP = 3'd4,
      OP_RD_LO = 3'd5,
      OP_WR_UP = 3'd6,
      OP_WR_LO = 3'd7
   } mdu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_RUN   = 2'd2
   } mdu_state_e;

endpackage

// File: rtl/mdu_mul_iter.sv
module mdu_mul_iter #(
   parameter int WIDTH = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic [WIDTH-1:0]     mcand_in,
   input  logic [WIDTH-1:0]     mplier_in,
   output logic [2*WIDTH-1:0]   prod_next
);
   localparam int PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic [PW-1:0]    acc_q;
   logic [WIDTH:0]   partial;

   // add the multiplicand when the current multiplier bit is set, then shift right
   always_comb begin
      partial   = {1'b0, acc_q[PW-1:WIDTH]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
      prod_next = {partial, acc_q[WIDTH-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         acc_q   <= '0;
      end else if (load) begin
         mcand_q <= mcand_in;
         acc_q   <= {{WIDTH{1'b0}}, mplier_in};
      end else if (step) begin
         acc_q   <= prod_next;
      end
   end

endmodule

// File: rtl/mdu_div_iter.sv
module mdu_div_iter #(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [WIDTH-1:0]   dividend_in,
   input  logic [WIDTH-1:0]   divisor_in,
   output logic [WIDTH-1:0]   quo_next,
   output logic [WIDTH-1:0]   rem_next
);
   logic [WIDTH-1:0] divisor_q;
   logic [WIDTH-1:0] rem_q;
   logic [WIDTH-1:0] quo_q;
   logic [WIDTH:0]   shifted;
   logic [WIDTH+1:0] trial;
   logic             too_small;

   // restoring step: bring down one dividend bit, subtract if it fits
   always_comb begin
      shifted   = {rem_q, quo_q[WIDTH-1]};
      trial     = {1'b0, shifted} - {2'b00, divisor_q};
      too_small = trial[WIDTH+1];
      rem_next  = too_small ? shifted[WIDTH-1:0] : trial[WIDTH-1:0];
      quo_next  = {quo_q[WIDTH-2:0], ~too_small};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divisor_q <= '0;
         rem_q     <= '0;
         quo_q     <= '0;
      end else if (load) begin
         divisor_q <= divisor_in;
         rem_q     <= '0;
         quo_q     <= dividend_in;
      end else if (step) begin
         rem_q     <= rem_next;
         quo_q     <= quo_next;
      end
   end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
   import mdu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [WIDTH-1:0]   opnd_a,
   input  logic [WIDTH-1:0]   opnd_b,
   output logic               busy,
   output logic               rd_valid,
   output logic [WIDTH-1:0]   rd_data
);
   localparam int CNT_W = $clog2(WIDTH) + 1;
   localparam int PW    = 2 * WIDTH;

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("muldiv_hilo: WIDTH must be at least 2");
      end
   endgenerate

   mdu_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              op_div_q;
   logic              op_uns_q;
   logic [WIDTH-1:0]  a_q;
   logic [WIDTH-1:0]  b_q;
   logic [WIDTH-1:0]  upper_q;
   logic [WIDTH-1:0]  lower_q;
   logic              rd_pend_q;
   logic              rd_sel_q;
   logic              rd_valid_q;
   logic [WIDTH-1:0]  rd_data_q;

   logic              cmd_rd;
   logic              finishing;
   logic              sel_eff;
   logic              neg_res;
   logic              rem_neg;
   logic [WIDTH-1:0]  mag_a;
   logic [WIDTH-1:0]  mag_b;
   logic [PW-1:0]     prod_next;
   logic [PW-1:0]     prod_fix;
   logic [WIDTH-1:0]  quo_next;
   logic [WIDTH-1:0]  rem_next;
   logic [WIDTH-1:0]  fin_up;
   logic [WIDTH-1:0]  fin_lo;

   always_comb begin
      cmd_rd    = cmd_valid & cmd_op[2] & ~cmd_op[1];
      finishing = (state_q == ST_RUN) && (cnt_q == CNT_W'(WIDTH - 1));
      sel_eff   = rd_pend_q ? rd_sel_q : cmd_op[0];
      neg_res   = ~op_uns_q & (a_q[WIDTH-1] ^ b_q[WIDTH-1]);
      rem_neg   = ~op_uns_q & a_q[WIDTH-1];
      mag_a     = (~op_uns_q & a_q[WIDTH-1]) ? (~a_q + 1'b1) : a_q;
      mag_b     = (~op_uns_q & b_q[WIDTH-1]) ? (~b_q + 1'b1) : b_q;
      prod_fix  = neg_res ? (~prod_next + 1'b1) : prod_next;
      if (op_div_q) begin
         fin_lo = neg_res ? (~quo_next + 1'b1) : quo_next;
         fin_up = rem_neg ? (~rem_next + 1'b1) : rem_next;
      end else begin
         fin_lo = prod_fix[WIDTH-1:0];
         fin_up = prod_fix[PW-1:WIDTH];
      end
   end

   mdu_mul_iter #(.WIDTH(WIDTH)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (state_q == ST_SETUP && !op_div_q),
      .step      (state_q == ST_RUN && !op_div_q),
      .mcand_in  (mag_a),
      .mplier_in (mag_b),
      .prod_next (prod_next)
   );

   mdu_div_iter #(.WIDTH(WIDTH)) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (state_q == ST_SETUP && op_div_q),
      .step        (state_q == ST_RUN && op_div_q),
      .dividend_in (mag_a),
      .divisor_in  (mag_b),
      .quo_next    (quo_next),
      .rem_next    (rem_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         op_div_q   <= 1'b0;
         op_uns_q   <= 1'b0;
         a_q        <= '0;
         b_q        <= '0;
         upper_q    <= '0;
         lower_q    <= '0;
         rd_pend_q  <= 1'b0;
         rd_sel_q   <= 1'b0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  if (!cmd_op[2]) begin
                     op_div_q <= cmd_op[1];
                     op_uns_q <= cmd_op[0];
                     a_q      <= opnd_a;
                     b_q      <= opnd_b;
                     state_q  <= ST_SETUP;
                  end else if (!cmd_op[1]) begin
                     rd_valid_q <= 1'b1;
                     rd_data_q  <= cmd_op[0] ? lower_q : upper_q;
                  end else if (cmd_op[0]) begin
                     lower_q <= opnd_a;
                  end else begin
                     upper_q <= opnd_a;
                  end
               end
            end
            ST_SETUP: begin
               cnt_q   <= '0;
               state_q <= ST_RUN;
               if (cmd_rd && !rd_pend_q) begin
                  rd_pend_q <= 1'b1;
                  rd_sel_q  <= cmd_op[0];
               end
            end
            default: begin
               if (finishing) begin
                  upper_q   <= fin_up;
                  lower_q   <= fin_lo;
                  state_q   <= ST_IDLE;
                  rd_pend_q <= 1'b0;
                  if (rd_pend_q || cmd_rd) begin
                     rd_valid_q <= 1'b1;
                     rd_data_q  <= sel_eff ? fin_lo : fin_up;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cmd_rd && !rd_pend_q) begin
                     rd_pend_q <= 1'b1;
                     rd_sel_q  <= cmd_op[0];
                  end
               end
            end
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
   parameter int WIDTH = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [2:0]         cmd_op,
   input logic               busy,
   input logic               rd_valid,
   input logic [WIDTH-1:0]   upper_q,
   input logic [WIDTH-1:0]   lower_q
);
   localparam int RW = $clog2(WIDTH + 2) + 1;

   logic [RW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == RW'(WIDTH + 1))); // R4

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !cmd_op[2]) |=> busy); // R4

   AST_RD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(cmd_valid && cmd_op[2:1] == 2'b10 && !busy) || $fell(busy))); // R5

   AST_RD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !busy); // R6

   AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(upper_q) && $stable(lower_q))); // R7

endmodule

bind muldiv_hilo mdu_checker #(.WIDTH(WIDTH)) u_mdu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .busy      (busy),
   .rd_valid  (rd_valid),
   .upper_q   (upper_q),
   .lower_q   (lower_q)
);

// File: tb/test_muldiv_hilo.sv
module test_muldiv_hilo;
   localparam int W = 4;
   localparam int M = 1 << W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic [W-1:0]  opnd_a = '0;
   logic [W-1:0]  opnd_b = '0;
   logic          busy;
   logic          rd_valid;
   logic [W-1:0]  rd_data;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   muldiv_hilo #(.WIDTH(W)) i_muldiv_hilo (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .rd_valid(rd_valid),
      .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int sx(input logic [W-1:0] v);
      return v[W-1] ? int'(v) - M : int'(v);
   endfunction

   task automatic send(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; opnd_a = a; opnd_b = b;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic read_reg(input bit lo, output logic [W-1:0] d, output logic v);
      send(lo ? 3'd5 : 3'd4, '0, '0);
      v = rd_valid;
      d = rd_data;
   endtask

   task automatic run_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         output int cyc);
      send(op, a, b);
      cyc = 0;
      while (busy && cyc < 100) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [W-1:0] d_up, d_lo, z_up, z_lo;
      logic v;
      int cyc;
      logic [31:0] pv;
      int q, r;
      logic [W-1:0] e_up, e_lo;
      bit skip;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs and zeroed registers
      chk("R1 busy", busy, 0);
      chk("R1 rd_valid", rd_valid, 0);
      read_reg(0, d_up, v);
      chk("R1 upper", d_up, 0);
      read_reg(1, d_lo, v);
      chk("R1 lower", d_lo, 0);

      // R8 write then R5 idle read strobe
      send(3'd6, 4'hA, '0);
      send(3'd7, 4'h5, '0);
      read_reg(0, d_up, v);
      chk("R5 strobe", v, 1);
      chk("R8 upper", d_up, 4'hA);
      @(negedge clk);
      chk("R5 single cycle", rd_valid, 0);
      read_reg(1, d_lo, v);
      chk("R8 lower", d_lo, 4'h5);

      // R2 / R3 / R4 exhaustive sweep over all operand pairs
      for (int op = 0; op < 4; op++) begin
         for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
               run_op(3'(op), W'(a), W'(b), cyc);
               chk("R4 busy span", cyc, W + 1);
               read_reg(0, d_up, v);
               read_reg(1, d_lo, v);
               skip = 0;
               if (op < 2) begin
                  pv = (op == 0) ? 32'(sx(W'(a)) * sx(W'(b))) : 32'(a * b);
                  e_up = pv[2*W-1:W];
                  e_lo = pv[W-1:0];
               end else if (b == 0) begin
                  skip = 1;
                  e_up = '0; e_lo = '0;
               end else begin
                  if (op == 2) begin
                     q = sx(W'(a)) / sx(W'(b));
                     r = sx(W'(a)) % sx(W'(b));
                  end else begin
                     q = a / b;
                     r = a % b;
                  end
                  e_lo = W'(q);
                  e_up = W'(r);
               end
               if (!skip) begin
                  chk(op < 2 ? "R2 upper" : "R3 upper", d_up, e_up);
                  chk(op < 2 ? "R2 lower" : "R3 lower", d_lo, e_lo);
               end
            end
         end
      end

      // R9 divide by zero: normal time, repeatable values
      for (int op = 2; op < 4; op++) begin
         run_op(3'(op), 4'd13, '0, cyc);
         chk("R9 busy span", cyc, W + 1);
         read_reg(0, z_up, v);
         read_reg(1, z_lo, v);
         send(3'd6, 4'h0, '0);
         run_op(3'(op), 4'd13, '0, cyc);
         chk("R9 busy span repeat", cyc, W + 1);
         read_reg(0, d_up, v);
         read_reg(1, d_lo, v);
         chk("R9 upper repeat", d_up, z_up);
         chk("R9 lower repeat", d_lo, z_lo);
      end

      // R6 read issued right after start is held off
      send(3'd1, 4'd3, 4'd5);
      chk("R6 busy after start", busy, 1);
      cmd_valid = 1'b1; cmd_op = 3'd5;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 0;
      while (busy && cyc < 100) begin
         if (rd_valid) chk("R6 no strobe while busy", rd_valid, 0);
         cyc++;
         @(negedge clk);
      end
      chk("R6 strobe at completion", rd_valid, 1);
      chk("R6 held read data", rd_data, 4'd15);

      // R6 read in the final busy cycle collides with the write of results
      send(3'd1, 4'd7, 4'd7);
      repeat (W) @(negedge clk);
      chk("R6 still busy in last cycle", busy, 1);
      cmd_valid = 1'b1; cmd_op = 3'd4;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R6 collision busy", busy, 0);
      chk("R6 collision strobe", rd_valid, 1);
      chk("R6 collision data", rd_data, 4'd3);

      // R7 start and write during busy are ignored
      send(3'd1, 4'd2, 4'd3);
      cyc = busy ? 1 : 0;
      cmd_valid = 1'b1; cmd_op = 3'd3; opnd_a = 4'd7; opnd_b = 4'd2;
      @(negedge clk);
      cyc += busy ? 1 : 0;
      cmd_op = 3'd6; opnd_a = 4'd9;
      @(negedge clk);
      cyc += busy ? 1 : 0;
      cmd_valid = 1'b0;
      while (busy && cyc < 100) begin
         @(negedge clk);
         if (busy) cyc++;
      end
      chk("R7 span not extended", cyc, W + 1);
      @(negedge clk);
      chk("R7 no restart", busy, 0);
      read_reg(0, d_up, v);
      chk("R7 upper unchanged by write", d_up, 4'd0);
      read_reg(1, d_lo, v);
      chk("R7 lower from original op", d_lo, 4'd6);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule